// File: doc/BRIEF.md
# Dual-Edge Pixel Capture Retimer

This block sits between a video source and a polling capture device. The source moves its 12-bit colour bus on both edges of a half-rate clock of about 7.1 MHz. It also supplies a second copy of that clock, offset by a quarter period. The two phases are XOR-ed, which gives a pixel-rate reference of about 14.2 MHz. The middle of every pixel is marked by a transition of that reference that comes from the quadrature phase while the main phase holds steady. That moment falls well after the roughly 30 ns the colour outputs need to settle.

The block runs on a fast local clock and oversamples both source phases. It waits a set number of local cycles after each mid-pixel transition, then loads the colour and sync bits into two 8-bit register banks. After a further set lag, it toggles its output pixel clock. A receiver that polls for a change of the pixel clock therefore always finds a complete, stable word already present. Each toggle, rising or falling, stands for one new pixel.

Top module: `dual_edge_pixel_retimer`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `pix_rgb`, `pix_sync` and `pix_clk` are all cleared to 0 at that edge.
- R2: `pix_clk` changes level exactly once for each captured pixel. It never changes without a capture, and it never changes twice for one capture.
- R3: A capture is triggered only when `src_ph0 ^ src_ph90` changes while `src_ph0` is steady, which means a change of `src_ph90` alone. The word presented is the value of `{src_sync, src_rgb}` at the (SYNC_STAGES + SETTLE_CYC + 2)-th rising `clk` edge after `src_ph90` changes. With the default parameters that is the 5th edge.
- R4: `pix_clk` toggles LAG_CYC rising edges after the edge that updates `pix_rgb`/`pix_sync`. With the defaults, the new word is visible for one `clk` cycle before the clock changes.
- R5: A change of `src_ph0` on its own starts no capture. `pix_rgb`, `pix_sync` and `pix_clk` keep their values even when the colour bus changes at the same time.
- R6: A value that is on the bus only in the settling window right after a `src_ph0` change, and is replaced before the capture point, never appears on `pix_rgb`.
- R7: Rising and falling changes of `src_ph90` each capture one pixel.
- R8: Bit positions are kept: `src_rgb[11:8]` red, `[7:4]` green, `[3:0]` blue map to the same `pix_rgb` bits. `pix_sync` is captured together with the colour word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_ph0 | input | 1 | Source half-rate clock, main phase |
| src_ph90 | input | 1 | Source half-rate clock, quarter-period shifted |
| src_rgb | input | 12 | Source colour bus {red, green, blue}, 4 bits each |
| src_sync | input | 1 | Source composite sync |
| pix_rgb | output | 12 | Registered colour word |
| pix_sync | output | 1 | Registered sync bit |
| pix_clk | output | 1 | Retimed pixel clock, one toggle per pixel |

## Verification
A change of `src_ph90` passes through two synchronizer stages and one history stage, and then SETTLE_CYC cycles of waiting. The new word therefore lands at the 5th rising edge after the change, and `pix_clk` follows one edge later. The bench drives each pixel as a 12-cycle slot. The quadrature phase changes on the falling edge of slot cycle 6. The word is checked on the falling edge of slot cycle 11, where it must be new while the clock still holds its old level. The clock toggle is checked at the start of the next slot. All sampling happens on falling edges, away from the edge that updates the design.

// File: rtl/pixret_pkg.sv
package pixret_pkg;
    // Default sizes shared by the retimer and its checker.
    localparam int CH_W_DEF   = 4;   // bits per colour channel
    localparam int BANK_W_DEF = 8;   // width of one holding register bank
    localparam int SYNC_DEF   = 2;   // synchronizer depth for the source phases

    // State of a wait-then-act delay unit.
    typedef enum logic {
        DLY_IDLE = 1'b0,
        DLY_WAIT = 1'b1
    } dly_state_t;
endpackage

// File: rtl/pixret_edge_track.sv
// Oversamples the two quadrature source phases and flags the mid-pixel
// transition: a change of (ph_main ^ ph_quad) while ph_main is steady.
// Assumes the local clock is several times faster than the pixel rate.
module pixret_edge_track #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ph_main,
    input  logic ph_quad,
    output logic mid_edge
);
    localparam int TOP = SYNC_STAGES;

    logic [TOP:0] main_q;
    logic [TOP:0] quad_q;
    logic         pix_now;
    logic         pix_prev;
    logic         main_steady;

    // Synchronizer chain plus one history stage for each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q <= '0;
            quad_q <= '0;
        end else begin
            main_q <= {main_q[TOP-1:0], ph_main};
            quad_q <= {quad_q[TOP-1:0], ph_quad};
        end
    end

    // Rebuild the pixel-rate clock and spot its mid-pixel transition.
    always_comb begin
        pix_now     = main_q[TOP-1] ^ quad_q[TOP-1];
        pix_prev    = main_q[TOP] ^ quad_q[TOP];
        main_steady = (main_q[TOP-1] == main_q[TOP]);
        mid_edge    = (pix_now != pix_prev) && main_steady;
    end
endmodule

// File: rtl/pixret_sampler.sv
// Waits SETTLE_CYC local cycles after a mid-pixel mark, then loads the
// input word into a row of BANK_W-wide holding registers.
// Assumes the input word is stable from the mark until the capture edge.
module pixret_sampler
    import pixret_pkg::*;
#(
    parameter int W          = 13,
    parameter int BANK_W     = 8,
    parameter int SETTLE_CYC = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mid_edge,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         cap_fire
);
    localparam int NBANK = (W + BANK_W - 1) / BANK_W;
    localparam int CNT_W = (SETTLE_CYC > 0) ? $clog2(SETTLE_CYC + 1) : 1;

    dly_state_t       st_q;
    logic [CNT_W-1:0] cnt_q;

    // Capture fires when the settle count has run out.
    assign cap_fire = (st_q == DLY_WAIT) && (cnt_q == '0);

    // Settle counter: armed by a mid-pixel mark, counts down to the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= DLY_IDLE;
            cnt_q <= '0;
        end else begin
            if (cap_fire) begin
                st_q <= DLY_IDLE;
            end else if (st_q == DLY_WAIT) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (mid_edge) begin
                st_q  <= DLY_WAIT;
                cnt_q <= CNT_W'(SETTLE_CYC);
            end
        end
    end

    // One holding bank per BANK_W slice of the word; the last one may be narrower.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int LO = b * BANK_W;
        localparam int BW = ((W - LO) < BANK_W) ? (W - LO) : BANK_W;
        logic [BW-1:0] bank_q;

        // Load this slice of the word on a capture.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q <= '0;
            end else if (cap_fire) begin
                bank_q <= din[LO +: BW];
            end
        end

        assign dout[LO +: BW] = bank_q;
    end
endmodule

// File: rtl/pixret_clk_lag.sv
// Toggles the output pixel clock LAG_CYC local cycles after each capture.
// This gives the receiver setup margin. LAG_CYC = 0 toggles on the capture edge.
// Assumes captures are spaced further apart than LAG_CYC cycles.
module pixret_clk_lag
    import pixret_pkg::*;
#(
    parameter int LAG_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_fire,
    output logic pclk
);
    logic pclk_q;
    assign pclk = pclk_q;

    if (LAG_CYC == 0) begin : g_nolag
        // Toggle together with the data update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pclk_q <= 1'b0;
            end else if (cap_fire) begin
                pclk_q <= ~pclk_q;
            end
        end
    end else begin : g_lag
        localparam int CNT_W = (LAG_CYC > 1) ? $clog2(LAG_CYC) : 1;
        dly_state_t       st_q;
        logic [CNT_W-1:0] cnt_q;
        logic             fire;

        assign fire = (st_q == DLY_WAIT) && (cnt_q == '0);

        // Lag counter: armed by a capture, toggles the clock when it runs out.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q   <= DLY_IDLE;
                cnt_q  <= '0;
                pclk_q <= 1'b0;
            end else begin
                if (fire) begin
                    st_q   <= DLY_IDLE;
                    pclk_q <= ~pclk_q;
                end else if (st_q == DLY_WAIT) begin
                    cnt_q <= cnt_q - 1'b1;
                end
                if (cap_fire) begin
                    st_q  <= DLY_WAIT;
                    cnt_q <= CNT_W'(LAG_CYC - 1);
                end
            end
        end
    end
endmodule

// File: rtl/dual_edge_pixel_retimer.sv
// Top level: rebuilds the pixel clock from two quadrature half-rate clocks,
// captures colour and sync mid-pixel, and presents them ahead of a lagged
// output clock edge. Assumes clk is much faster than the pixel rate.
module dual_edge_pixel_retimer
    import pixret_pkg::*;
#(
    parameter int CH_W        = CH_W_DEF,
    parameter int BANK_W      = BANK_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF,
    parameter int SETTLE_CYC  = 1,
    parameter int LAG_CYC     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_ph0,
    input  logic              src_ph90,
    input  logic [3*CH_W-1:0] src_rgb,
    input  logic              src_sync,
    output logic [3*CH_W-1:0] pix_rgb,
    output logic              pix_sync,
    output logic              pix_clk
);
    localparam int RGB_W  = 3 * CH_W;
    localparam int WORD_W = RGB_W + 1;

    logic              mid_edge;
    logic              cap_fire;
    logic [WORD_W-1:0] word_in;
    logic [WORD_W-1:0] word_out;

    assign word_in = {src_sync, src_rgb};

    pixret_edge_track #(
        .SYNC_STAGES (SYNC_STAGES)
    ) edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph_main  (src_ph0),
        .ph_quad  (src_ph90),
        .mid_edge (mid_edge)
    );

    pixret_sampler #(
        .W          (WORD_W),
        .BANK_W     (BANK_W),
        .SETTLE_CYC (SETTLE_CYC)
    ) samp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mid_edge (mid_edge),
        .din      (word_in),
        .dout     (word_out),
        .cap_fire (cap_fire)
    );

    pixret_clk_lag #(
        .LAG_CYC (LAG_CYC)
    ) lag_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_fire (cap_fire),
        .pclk     (pix_clk)
    );

    assign pix_rgb  = word_out[RGB_W-1:0];
    assign pix_sync = word_out[RGB_W];
endmodule

// File: rtl/pixret_chk.sv
// Checker for the retimer: reset state, one clock toggle per capture,
// output word changing only on a capture, and the fixed clock lag.
module pixret_chk #(
    parameter int RGB_W   = 12,
    parameter int LAG_CYC = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_fire,
    input logic             pix_clk,
    input logic [RGB_W-1:0] pix_rgb,
    input logic             pix_sync
);
    localparam int SW = $clog2(LAG_CYC + 2) + 1;

    logic          clk_prev;
    logic          pending_q;
    logic [SW-1:0] since_q;
    logic          toggle_seen;

    assign toggle_seen = (pix_clk != clk_prev);

    // Track the last pixel clock level, any unanswered capture, and the age of the last capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev  <= 1'b0;
            pending_q <= 1'b0;
            since_q   <= '0;
        end else begin
            clk_prev <= pix_clk;
            if (cap_fire) begin
                pending_q <= 1'b1;
                since_q   <= '0;
            end else begin
                if (toggle_seen) pending_q <= 1'b0;
                if (since_q != '1) since_q <= since_q + 1'b1;
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pix_clk == 1'b0 && pix_rgb == '0 && pix_sync == 1'b0)); // R1

    AST_TOGGLE_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_seen |-> pending_q); // R2

    AST_NO_DOUBLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |-> !pending_q); // R2

    AST_WORD_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pix_rgb) || !$stable(pix_sync)) |-> $past(cap_fire)); // R3

    AST_CLOCK_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_seen |-> (since_q == SW'(LAG_CYC))); // R4
endmodule

bind dual_edge_pixel_retimer pixret_chk #(
    .RGB_W   (RGB_W),
    .LAG_CYC (LAG_CYC)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_fire (cap_fire),
    .pix_clk  (pix_clk),
    .pix_rgb  (pix_rgb),
    .pix_sync (pix_sync)
);

// File: tb/dual_edge_pixel_retimer_tb_top.sv
module dual_edge_pixel_retimer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_ph0 = 1'b0;
    logic        src_ph90 = 1'b0;
    logic [11:0] src_rgb = '0;
    logic        src_sync = 1'b0;
    logic [11:0] pix_rgb;
    logic        pix_sync;
    logic        pix_clk;

    int checks = 0;
    int errors = 0;
    logic        exp_clk = 1'b0;
    logic [12:0] exp_word = '0;

    // Stimulus table {sync, red, green, blue} with expected output equal to the entry.
    localparam logic [12:0] VEC [8] = '{
        13'h1F00, 13'h00F0, 13'h100F, 13'h0FFF,
        13'h1A5C, 13'h0000, 13'h1123, 13'h0C3A
    };

    always #4 clk = ~clk;

    dual_edge_pixel_retimer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_ph0  (src_ph0),
        .src_ph90 (src_ph90),
        .src_rgb  (src_rgb),
        .src_sync (src_sync),
        .pix_rgb  (pix_rgb),
        .pix_sync (pix_sync),
        .pix_clk  (pix_clk)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One 12-cycle pixel slot: ph0 edge with a garbage word, valid word at 3, ph90 edge at 6.
    task automatic run_slot(input logic [12:0] w, input bit do_mid, input string req);
        logic [12:0] want;
        want = do_mid ? w : exp_word;
        for (int j = 0; j < 12; j++) begin
            @(negedge clk);
            if (j == 0) begin
                chk(pix_clk == exp_clk, "R2 clock toggle per pixel", 16'(pix_clk), 16'(exp_clk));
                src_ph0 = ~src_ph0;
                {src_sync, src_rgb} = ~w;
            end
            if (j == 3) {src_sync, src_rgb} = w;
            if (j == 6 && do_mid) src_ph90 = ~src_ph90;
            if (j == 11) begin
                chk({pix_sync, pix_rgb} == want, req, 16'({pix_sync, pix_rgb}), 16'(want));
                chk(pix_clk == exp_clk, "R4 clock still old with new word", 16'(pix_clk), 16'(exp_clk));
            end
        end
        exp_word = want;
        exp_clk  = exp_clk ^ do_mid;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(pix_rgb == '0 && !pix_sync, "R1 word cleared", 16'({pix_sync, pix_rgb}), 16'h0);
        chk(pix_clk == 1'b0, "R1 clock cleared", 16'(pix_clk), 16'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Table walk: ph90 alternates rising/falling (R7), garbage first (R6), bit map (R8), timing (R3)
        for (int i = 0; i < 8; i++) begin
            run_slot(VEC[i], 1'b1, (i % 2 == 0) ? "R3 R6 R8 word on rising ph90" : "R7 R3 word on falling ph90");
        end

        // R5: ph0 change alone with a new bus value captures nothing
        run_slot(13'h1BEE, 1'b0, "R5 ph0 alone ignored");
        run_slot(13'h0777, 1'b1, "R3 capture after ignored slot");
        @(negedge clk);
        chk(pix_clk == exp_clk, "R2 final toggle", 16'(pix_clk), 16'(exp_clk));

        // R1: reset in mid-run clears outputs
        rst_n = 1'b0;
        src_ph0 = 1'b0;
        src_ph90 = 1'b0;
        repeat (2) @(negedge clk);
        chk({pix_sync, pix_rgb} == 13'h0, "R1 mid-run word cleared", 16'({pix_sync, pix_rgb}), 16'h0);
        chk(pix_clk == 1'b0, "R1 mid-run clock cleared", 16'(pix_clk), 16'h0);
        rst_n = 1'b1;
        exp_clk = 1'b0;
        exp_word = '0;
        repeat (3) @(negedge clk);
        run_slot(13'h1ABC, 1'b1, "R8 word after reset");
        @(negedge clk);
        chk(pix_clk == exp_clk, "R2 toggle after reset", 16'(pix_clk), 16'(exp_clk));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule